// File: doc/BRIEF.md
# Slave-Port Grant Controller with Idle Parking

This block decides which of several bus masters owns one slave port of a multi-layer interconnect. Masters raise request lines. The slave port signals when the ongoing transfer is finished. The block drives a one-hot grant vector, a flag showing that the slave is connected to some master, and a flag showing that a transfer is in progress. An interconnect places one instance in front of every slave.

When a transfer completes and no master is waiting, the slave is parked according to a programmable idle policy. The policy can release the slave completely, which saves power. It can keep the slave with the master that just used it. It can also hand the slave to one chosen master. A master that finds the slave already parked on itself starts its next access with no arbitration cycle.

A small write port loads the policy and the index of the chosen master. The block samples the stored setting only at the end of a transfer, so a write never disturbs an access that is already running.

Top module: `slave_park_arbiter`

## Requirements
- R1: After reset no grant bit is set, `slvConnected` and `slvBusy` are low, and the stored idle policy is the release policy (2'b00).
- R2: `mstGrant` has at most one bit set, bit i standing for master i, and `slvConnected` is high exactly when one grant bit is set.
- R3: While no transfer is in progress, a request from a master that does not currently hold the grant is answered one clock later. On that edge the winner's grant bit rises and `slvBusy` goes high.
- R4: While no transfer is in progress, if the master already holding the grant requests, its transfer starts at once. The grant does not change, `slvBusy` rises on the next edge, and requests from other masters in that cycle lose.
- R5: Once a transfer is in progress, the grant stays fixed until `slvXferEnd` is high. The winner among several requests is the first requester found in round-robin order, starting with the master after the current owner and wrapping from master NUM_MASTERS-1 to master 0.
- R6: If any request is high in the cycle where `slvXferEnd` ends a transfer, the round-robin winner is granted on the next edge and `slvBusy` stays high. The current owner wins again only when it is the only requester.
- R7: With policy 2'b00, or with the reserved value 2'b11, a transfer that ends with no request pending leaves the slave disconnected and all grant bits low.
- R8: With policy 2'b01, a transfer that ends with no request pending leaves the grant with the master that owned that transfer.
- R9: With policy 2'b10, a transfer that ends with no request pending moves the grant to the master named by the stored 3-bit index, even if that master did not own the transfer.
- R10: Under policy 2'b10, a stored index of NUM_MASTERS or more disconnects the slave at the end of a transfer.
- R11: The stored master index has no effect on parking unless the policy is 2'b10.
- R12: A configuration write (`cfgWrEn` high) changes nothing at the outputs by itself. A write taken before the ending cycle of a transfer decides how that transfer parks. A write in the same cycle as `slvXferEnd` takes effect only from the following transfer end.
- R13: `slvXferEnd` is ignored while no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| mstReq | input | NUM_MASTERS | Request line per master, bit i for master i |
| slvXferEnd | input | 1 | Slave port reports that the current transfer finishes this cycle |
| cfgWrEn | input | 1 | Write strobe for the idle-policy register |
| cfgWrPolicy | input | 2 | Idle policy: 00 release, 01 keep last owner, 10 chosen master, 11 reserved (release) |
| cfgWrFixedIdx | input | IDX_W | Index of the chosen master for policy 10 |
| mstGrant | output | NUM_MASTERS | One-hot grant, bit i for master i |
| slvConnected | output | 1 | Slave is attached to some master |
| slvBusy | output | 1 | A transfer is in progress |

## Verification
The bench uses the default build of five masters and a 3-bit index. Index values 5, 6 and 7 are therefore legal to write but name no master, and the out-of-range parking path can be exercised directly. With five masters, the round-robin wrap from master 4 back to master 0 occurs within a few transfers. Starting arbitration from different owners also shows that the search begins after the owner and not at a fixed master. A behavioural model with integer state is compared with the outputs on every cycle. Hand-derived checkpoints pin down the parking, handover and configuration-timing cases.

// File: rtl/slave_park_pkg.sv
package slave_park_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'b00,
    PARK_LAST  = 2'b01,
    PARK_FIXED = 2'b10,
    PARK_RSVD  = 2'b11
  } parkPolicy_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWinner;  // owner <= round-robin winner, connect
    logic loadFixed;   // owner <= stored fixed index, connect
    logic dropConn;    // disconnect the slave
  } ctrlStrobe_t;

endpackage

// File: rtl/slave_park_rr.sv
module slave_park_rr #(
  parameter int NUM_MASTERS = 5,
  parameter int IDX_W       = 3
) (
  input  logic [NUM_MASTERS-1:0] reqVec,
  input  logic [IDX_W-1:0]       lastIdx,
  output logic [IDX_W-1:0]       winIdx,
  output logic                   winValid
);

  // Search starts after lastIdx and wraps; lastIdx itself is checked last.
  always_comb begin
    logic [IDX_W-1:0] candIdx;
    winIdx   = '0;
    winValid = 1'b0;
    candIdx  = '0;
    for (int k = 1; k <= NUM_MASTERS; k++) begin
      candIdx = IDX_W'((int'(lastIdx) + k) % NUM_MASTERS);
      if (!winValid && reqVec[candIdx]) begin
        winValid = 1'b1;
        winIdx   = candIdx;
      end
    end
  end

endmodule

// File: rtl/slave_park_dp.sv
module slave_park_dp
  import slave_park_pkg::*;
#(
  parameter int NUM_MASTERS = 5,
  parameter int IDX_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] mstReq,
  input  logic                   cfgWrEn,
  input  logic [1:0]             cfgWrPolicy,
  input  logic [IDX_W-1:0]       cfgWrFixedIdx,
  input  ctrlStrobe_t            strobe,
  output logic                   anyReq,
  output logic                   ownerReq,
  output logic                   fixedOk,
  output parkPolicy_t            policy,
  output logic [NUM_MASTERS-1:0] grant,
  output logic                   connected
);

  localparam logic [IDX_W:0] MST_COUNT = (IDX_W+1)'(NUM_MASTERS);

  logic [IDX_W-1:0] ownerIdx;
  logic [IDX_W-1:0] fixedIdx;
  logic [IDX_W-1:0] winIdx;
  logic             connReg;

  slave_park_rr #(
    .NUM_MASTERS(NUM_MASTERS),
    .IDX_W      (IDX_W)
  ) u_rr (
    .reqVec  (mstReq),
    .lastIdx (ownerIdx),
    .winIdx  (winIdx),
    .winValid(anyReq)
  );

  // Policy register: sampled by control only at transfer end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      policy   <= PARK_NONE;
      fixedIdx <= '0;
    end else if (cfgWrEn) begin
      policy   <= parkPolicy_t'(cfgWrPolicy);
      fixedIdx <= cfgWrFixedIdx;
    end
  end

  // Owner and connection state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerIdx <= '0;
      connReg  <= 1'b0;
    end else if (strobe.loadWinner) begin
      ownerIdx <= winIdx;
      connReg  <= 1'b1;
    end else if (strobe.loadFixed) begin
      ownerIdx <= fixedIdx;
      connReg  <= 1'b1;
    end else if (strobe.dropConn) begin
      connReg  <= 1'b0;
    end
  end

  assign fixedOk   = ({1'b0, fixedIdx} < MST_COUNT);
  assign ownerReq  = connReg && mstReq[ownerIdx];
  assign connected = connReg;

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_grant
    assign grant[g] = connReg && (ownerIdx == IDX_W'(g));
  end

  // R2: never more than one owner
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R10: a connected owner always names a real master
  p_owner_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    connReg |-> ({1'b0, ownerIdx} < MST_COUNT));

endmodule

// File: rtl/slave_park_ctrl.sv
module slave_park_ctrl
  import slave_park_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        slvXferEnd,
  input  logic        anyReq,
  input  logic        ownerReq,
  input  logic        fixedOk,
  input  parkPolicy_t policy,
  output ctrlStrobe_t strobe,
  output logic        busy
);

  logic busyNext;

  always_comb begin
    strobe   = '0;
    busyNext = busy;
    if (!busy) begin
      // Idle: parked owner goes straight on, others arbitrate
      if (ownerReq) begin
        busyNext = 1'b1;
      end else if (anyReq) begin
        strobe.loadWinner = 1'b1;
        busyNext          = 1'b1;
      end
    end else if (slvXferEnd) begin
      if (anyReq) begin
        strobe.loadWinner = 1'b1;
      end else begin
        busyNext = 1'b0;
        case (policy)
          PARK_LAST:  ;
          PARK_FIXED: begin
            if (fixedOk) strobe.loadFixed = 1'b1;
            else         strobe.dropConn  = 1'b1;
          end
          default:    strobe.dropConn = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= busyNext;
  end

  // R6: a pending request at transfer end keeps the port busy
  p_handover_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && slvXferEnd && anyReq) |=> busy);

  // R13: end indication while idle does not start anything
  p_idle_end_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyReq) |=> !busy);

endmodule

// File: rtl/slave_park_arbiter.sv
module slave_park_arbiter
  import slave_park_pkg::*;
#(
  parameter int NUM_MASTERS = 5,
  parameter int IDX_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] mstReq,
  input  logic                   slvXferEnd,
  input  logic                   cfgWrEn,
  input  logic [1:0]             cfgWrPolicy,
  input  logic [IDX_W-1:0]       cfgWrFixedIdx,
  output logic [NUM_MASTERS-1:0] mstGrant,
  output logic                   slvConnected,
  output logic                   slvBusy
);

  ctrlStrobe_t strobe;
  parkPolicy_t policy;
  logic        anyReq;
  logic        ownerReq;
  logic        fixedOk;

  slave_park_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .slvXferEnd(slvXferEnd),
    .anyReq    (anyReq),
    .ownerReq  (ownerReq),
    .fixedOk   (fixedOk),
    .policy    (policy),
    .strobe    (strobe),
    .busy      (slvBusy)
  );

  slave_park_dp #(
    .NUM_MASTERS(NUM_MASTERS),
    .IDX_W      (IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .mstReq       (mstReq),
    .cfgWrEn      (cfgWrEn),
    .cfgWrPolicy  (cfgWrPolicy),
    .cfgWrFixedIdx(cfgWrFixedIdx),
    .strobe       (strobe),
    .anyReq       (anyReq),
    .ownerReq     (ownerReq),
    .fixedOk      (fixedOk),
    .policy       (policy),
    .grant        (mstGrant),
    .connected    (slvConnected)
  );

  // R5: grant frozen during a transfer
  p_hold_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    (slvBusy && !slvXferEnd) |=> $stable(mstGrant));

  // R4: parked owner starts without re-arbitration
  p_parked_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!slvBusy && |(mstReq & mstGrant)) |=> (slvBusy && $stable(mstGrant)));

  // R7: release policies disconnect on an idle end
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slvBusy && slvXferEnd && !(|mstReq) &&
     (policy == PARK_NONE || policy == PARK_RSVD)) |=> !slvConnected);

  // R8: keep-last policy holds the grant on an idle end
  p_keep_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slvBusy && slvXferEnd && !(|mstReq) && policy == PARK_LAST)
      |=> $stable(mstGrant));

  // R10: fixed policy with an unusable index releases the slave
  p_fixed_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    (slvBusy && slvXferEnd && !(|mstReq) && policy == PARK_FIXED && !fixedOk)
      |=> !slvConnected);

  // R13: idle end with nothing pending changes no grant
  p_idle_end_stable_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!slvBusy && !(|mstReq)) |=> $stable(mstGrant));

endmodule

// File: tb/slave_park_arbiter_bench.sv
module slave_park_arbiter_bench;

  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] mstReq;
  logic       slvXferEnd;
  logic       cfgWrEn;
  logic [1:0] cfgWrPolicy;
  logic [2:0] cfgWrFixedIdx;
  logic [4:0] mstGrant;
  logic       slvConnected;
  logic       slvBusy;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // Reference model state
  int mOwner, mPol, mFix;
  bit mConn, mBusy;

  always #10 clk = ~clk;

  slave_park_arbiter u_slave_park_arbiter (
    .clk(clk), .rstN(rstN), .mstReq(mstReq), .slvXferEnd(slvXferEnd),
    .cfgWrEn(cfgWrEn), .cfgWrPolicy(cfgWrPolicy), .cfgWrFixedIdx(cfgWrFixedIdx),
    .mstGrant(mstGrant), .slvConnected(slvConnected), .slvBusy(slvBusy)
  );

  function automatic int rrPick(logic [4:0] r, int from);
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (from + k) % N;
      if (r[c]) return c;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOwner = 0; mConn = 0; mBusy = 0; mPol = 0; mFix = 0;
    end else begin
      int w;
      w = rrPick(mstReq, mOwner);
      if (!mBusy) begin
        if (mConn && mstReq[mOwner]) mBusy = 1;
        else if (w >= 0) begin mOwner = w; mConn = 1; mBusy = 1; end
      end else if (slvXferEnd) begin
        if (w >= 0) begin mOwner = w; mConn = 1; end
        else begin
          mBusy = 0;
          if (mPol == 1) ;
          else if (mPol == 2 && mFix < N) begin mOwner = mFix; mConn = 1; end
          else mConn = 0;
        end
      end
      if (cfgWrEn) begin mPol = int'(cfgWrPolicy); mFix = int'(cfgWrFixedIdx); end
    end
  end

  function automatic logic [4:0] modelGrant();
    return mConn ? 5'(1 << mOwner) : 5'b0;
  endfunction

  task automatic compareModel();
    checks++;
    if (mstGrant !== modelGrant() || slvConnected !== mConn || slvBusy !== mBusy) begin
      errors++;
      $display("FAIL %s model: actual g=%b c=%b b=%b expected g=%b c=%b b=%b",
               curReq, mstGrant, slvConnected, slvBusy, modelGrant(), mConn, mBusy);
    end
    checks++;
    if ($countones(mstGrant) > 1 || slvConnected !== (|mstGrant)) begin
      errors++;
      $display("FAIL R2 shape: actual g=%b c=%b expected onehot0 with matching flag",
               mstGrant, slvConnected);
    end
  endtask

  task automatic step(input logic [4:0] r, input logic e, input logic w,
                      input logic [1:0] p, input logic [2:0] f);
    mstReq = r; slvXferEnd = e; cfgWrEn = w; cfgWrPolicy = p; cfgWrFixedIdx = f;
    @(posedge clk);
    @(negedge clk);
    mstReq = '0; slvXferEnd = 0; cfgWrEn = 0;
    compareModel();
  endtask

  task automatic run(input logic [4:0] r, input logic e);
    step(r, e, 1'b0, 2'b00, 3'd0);
  endtask

  task automatic wcfg(input logic [1:0] p, input logic [2:0] f);
    step(5'b0, 1'b0, 1'b1, p, f);
  endtask

  task automatic expect3(input logic [4:0] g, input logic c, input logic b, input string tag);
    checks++;
    if (mstGrant !== g || slvConnected !== c || slvBusy !== b) begin
      errors++;
      $display("FAIL %s: actual g=%b c=%b b=%b expected g=%b c=%b b=%b",
               tag, mstGrant, slvConnected, slvBusy, g, c, b);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; mstReq = '0; slvXferEnd = 0; cfgWrEn = 0; cfgWrPolicy = 0; cfgWrFixedIdx = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R1"; expect3(5'b00000, 0, 0, "R1");
    curReq = "R3"; run(5'b00100, 0); expect3(5'b00100, 1, 1, "R3");
    curReq = "R5"; run(5'b01101, 0); run(5'b01101, 0); expect3(5'b00100, 1, 1, "R5");
    curReq = "R6"; run(5'b01001, 1); expect3(5'b01000, 1, 1, "R6");
    curReq = "R5"; run(5'b01001, 1); expect3(5'b00001, 1, 1, "R5");
    curReq = "R7"; run(5'b0, 1); expect3(5'b00000, 0, 0, "R7");
    curReq = "R13"; run(5'b0, 1); run(5'b0, 1); expect3(5'b00000, 0, 0, "R13");
    curReq = "R12"; wcfg(2'b01, 3'd3); expect3(5'b00000, 0, 0, "R12");
    curReq = "R3"; run(5'b10000, 0); expect3(5'b10000, 1, 1, "R3");
    curReq = "R11"; run(5'b0, 1); expect3(5'b10000, 1, 0, "R8 R11");
    curReq = "R4"; run(5'b10010, 0); expect3(5'b10000, 1, 1, "R4");
    curReq = "R8"; run(5'b0, 1); expect3(5'b10000, 1, 0, "R8");
    curReq = "R12"; wcfg(2'b10, 3'd1); expect3(5'b10000, 1, 0, "R12");
    curReq = "R3"; run(5'b00100, 0); expect3(5'b00100, 1, 1, "R3");
    curReq = "R9"; run(5'b0, 1); expect3(5'b00010, 1, 0, "R9");
    curReq = "R4"; run(5'b00010, 0); expect3(5'b00010, 1, 1, "R4");
    curReq = "R12"; step(5'b0, 0, 1, 2'b00, 3'd0); expect3(5'b00010, 1, 1, "R12");
    run(5'b0, 1); expect3(5'b00000, 0, 0, "R12");
    curReq = "R3"; run(5'b00001, 0); expect3(5'b00001, 1, 1, "R3");
    curReq = "R12"; step(5'b0, 1, 1, 2'b01, 3'd0); expect3(5'b00000, 0, 0, "R12");
    run(5'b00010, 0); expect3(5'b00010, 1, 1, "R12");
    run(5'b0, 1); expect3(5'b00010, 1, 0, "R12");
    curReq = "R10"; wcfg(2'b10, 3'd6); run(5'b00100, 0); expect3(5'b00100, 1, 1, "R10");
    run(5'b0, 1); expect3(5'b00000, 0, 0, "R10");
    wcfg(2'b10, 3'd5); run(5'b00001, 0); expect3(5'b00001, 1, 1, "R10");
    run(5'b0, 1); expect3(5'b00000, 0, 0, "R10");
    curReq = "R7"; wcfg(2'b11, 3'd2); run(5'b01000, 0); expect3(5'b01000, 1, 1, "R7");
    run(5'b0, 1); expect3(5'b00000, 0, 0, "R7 R11");
    curReq = "R6"; run(5'b00100, 0); expect3(5'b00100, 1, 1, "R6");
    run(5'b00100, 1); expect3(5'b00100, 1, 1, "R6");
    run(5'b0, 1); expect3(5'b00000, 0, 0, "R7");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule